// File: doc/BRIEF.md
# Serial Control Port for a Frequency Synthesiser

This block receives the control word of a PLL frequency synthesiser over a three-wire serial link made of data, clock and enable lines. While enable is high, each rising serial-clock edge shifts one data bit into a shift register, most-significant bit first. When enable falls, the shifted word is staged. It is copied into the controlling registers only when the programmable divider reports the end of its cycle, so that a retune never cuts a divider cycle short.

The controlling registers are decoded into the following controls:
- the 17-bit divider ratio,
- the prescaler enable,
- the 3-bit reference-ratio code,
- the charge-pump current select,
- the drive-off control,
- the test enable,
- the switching-port levels.

In test mode, two ports are taken over. One carries the halved divider output and the other carries the comparison frequency. Test mode combined with an asserted charge-pump disable input is a forbidden state and raises a flag. A word whose length is wrong also raises a flag.

All serial inputs are sampled on the system clock `clk_i`. The serial clock must therefore run well below the system clock. The full-width build uses four ports and a 28-bit word. Setting `NUM_PORTS` to 2 gives the reduced 26-bit word.

Top module: `synth_ctl_port`

## Requirements
- R1: After reset, every decoded control, every port bit, `len_err_o` and `illegal_o` are 0, and no load is pending.
- R2: The word is taken MSB first on rising `sclk_i` edges while `sen_i` is high. Its fields are decoded from the committed word as follows:
  - bits [16:0]: divider ratio
  - bit 17: prescaler enable
  - bits [20:18]: reference code
  - bit 21: charge-pump current select
  - bit 22: drive off
  - bit 23: test enable
- R3: Serial-clock edges that arrive while `sen_i` is low change nothing.
- R4: The falling edge of `sen_i` stages the word. The decoded outputs keep their old values until a `div_tc_i` pulse, and they change in the cycle after that pulse.
- R5: A staged word stays pending for any number of cycles. A later word sent before the next `div_tc_i` replaces it.
- R6: With test enable at 0, `port_o[i]` equals word bit 24+i.
- R7: With test enable at 1:
  - `port_o[0]` follows `fpd_half_i`.
  - `port_o[1]` follows `fcomp_i`.
  - The higher ports still follow their word bits.
- R8: `illegal_o` is 1 exactly when test enable is 1 and `cp_disable_i` is 1.
- R9: At each falling edge of `sen_i`, `len_err_o` is set to 1 if the number of bits shifted differs from the word length, and to 0 otherwise. The staged word is always the last word-length bits shifted, including bits kept from earlier words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock |
| sdata_i | input | 1 | Serial data |
| sen_i | input | 1 | Serial enable, word framing |
| div_tc_i | input | 1 | Divider end-of-cycle pulse |
| fpd_half_i | input | 1 | Halved divider output, used in test mode |
| fcomp_i | input | 1 | Comparison frequency, used in test mode |
| cp_disable_i | input | 1 | Charge-pump disable input |
| div_ratio_o | output | 17 | Programmable divider ratio |
| presc_en_o | output | 1 | Divide-by-two prescaler enable |
| ref_code_o | output | 3 | Reference-ratio code |
| cp_cur_o | output | 1 | Charge-pump current select |
| drive_off_o | output | 1 | Varactor drive disable |
| test_en_o | output | 1 | Test mode enable |
| port_o | output | NUM_PORTS | Switching-port levels |
| len_err_o | output | 1 | Word-length error flag of the last frame |
| illegal_o | output | 1 | Forbidden test/charge-pump-disable combination |

## Verification
- **Correct 28-bit words with distinct field values.** These show that the fields are decoded from the right positions. A word sent and then left waiting across idle cycles separates an immediate commit from a commit held for `div_tc_i`. Two words sent back to back before one commit show that the newer word replaces the older one.
- **Serial-clock toggles with enable low, followed by an empty frame.** Any shift that leaks through would show up in the committed divider ratio.
- **Frames of 0, 20 and 30 bits, then a correct frame.** These test the length flag in both directions and the retention of older bits.
- **Test mode with toggling test inputs and the charge-pump disable input.** This tells port takeover apart from the port bits.

// File: rtl/synth_ctl_pkg.sv
package synth_ctl_pkg;
  localparam int DIV_W    = 17;
  localparam int REF_W    = 3;
  localparam int POS_DE   = DIV_W;
  localparam int POS_REF  = POS_DE + 1;
  localparam int POS_CP   = POS_REF + REF_W;
  localparam int POS_OS   = POS_CP + 1;
  localparam int POS_TST  = POS_OS + 1;
  localparam int POS_PORT = POS_TST + 1;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             presc;
    logic [REF_W-1:0] refc;
    logic             cp;
    logic             drv_off;
    logic             tst;
  } ctl_t;
endpackage

// File: rtl/sctl_shift_rx.sv
module sctl_shift_rx #(
  parameter int WORD_W = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              sen_i,
  output logic [WORD_W-1:0] word_o,
  output logic              load_o,
  output logic              len_err_o
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_OK  = CNT_W'(WORD_W);

  logic              sclk_q, sen_q, len_err_q;
  logic [WORD_W-1:0] sr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              shift, fall, rise;

  assign fall  = sen_q & ~sen_i;
  assign rise  = sen_i & ~sen_q;
  // shift only once enable has been high for a full sample
  assign shift = sclk_i & ~sclk_q & sen_i & sen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q    <= 1'b0;
      sen_q     <= 1'b0;
      sr_q      <= '0;
      cnt_q     <= '0;
      len_err_q <= 1'b0;
    end else begin
      sclk_q <= sclk_i;
      sen_q  <= sen_i;
      if (fall) begin
        len_err_q <= (cnt_q != CNT_OK);
        cnt_q     <= '0;
      end else if (rise) begin
        cnt_q <= '0;
      end else if (shift) begin
        sr_q <= {sr_q[WORD_W-2:0], sdata_i};
        if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign word_o    = sr_q;
  assign load_o    = fall;
  assign len_err_o = len_err_q;

  AST_SHIFT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sen_i |=> $stable(sr_q)); // R3
  AST_LEN_ERR_ONLY_AT_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fall |=> $stable(len_err_q)); // R9
endmodule

// File: rtl/sctl_load_sync.sv
module sctl_load_sync #(
  parameter int WORD_W = 28
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              div_tc_i,
  output logic [WORD_W-1:0] hold_o
);
  logic [WORD_W-1:0] staged_q, hold_q;
  logic              pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      staged_q <= '0;
      hold_q   <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (pend_q && div_tc_i) begin
        hold_q <= staged_q;
        pend_q <= 1'b0;
      end
      // a new frame wins over a same-cycle commit
      if (load_i) begin
        staged_q <= word_i;
        pend_q   <= 1'b1;
      end
    end
  end

  assign hold_o = hold_q;

  AST_HOLD_NEEDS_TC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !div_tc_i |=> $stable(hold_q)); // R4
  AST_COMMIT_ON_TC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && div_tc_i) |=> (hold_q == $past(staged_q))); // R4
  AST_PEND_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> pend_q); // R5
endmodule

// File: rtl/sctl_port_mux.sv
module sctl_port_mux #(
  parameter int NUM_PORTS = 4
) (
  input  logic [NUM_PORTS-1:0] bits_i,
  input  logic                 tst_i,
  input  logic                 fpd_half_i,
  input  logic                 fcomp_i,
  output logic [NUM_PORTS-1:0] port_o
);
  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    if (i == 0) begin : g_p0
      assign port_o[i] = tst_i ? fpd_half_i : bits_i[i];
    end else if (i == 1) begin : g_p1
      assign port_o[i] = tst_i ? fcomp_i : bits_i[i];
    end else begin : g_pn
      assign port_o[i] = bits_i[i];
    end
  end
endmodule

// File: rtl/synth_ctl_port.sv
module synth_ctl_port
  import synth_ctl_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sclk_i,
  input  logic                 sdata_i,
  input  logic                 sen_i,
  input  logic                 div_tc_i,
  input  logic                 fpd_half_i,
  input  logic                 fcomp_i,
  input  logic                 cp_disable_i,
  output logic [DIV_W-1:0]     div_ratio_o,
  output logic                 presc_en_o,
  output logic [REF_W-1:0]     ref_code_o,
  output logic                 cp_cur_o,
  output logic                 drive_off_o,
  output logic                 test_en_o,
  output logic [NUM_PORTS-1:0] port_o,
  output logic                 len_err_o,
  output logic                 illegal_o
);
  localparam int WORD_W = POS_PORT + NUM_PORTS;

  logic [WORD_W-1:0] word, hold;
  logic              load;
  ctl_t              ctl;

  sctl_shift_rx #(.WORD_W(WORD_W)) u_rx (
    .clk_i, .rst_ni, .sclk_i, .sdata_i, .sen_i,
    .word_o(word), .load_o(load), .len_err_o
  );

  sctl_load_sync #(.WORD_W(WORD_W)) u_sync (
    .clk_i, .rst_ni, .load_i(load), .word_i(word), .div_tc_i, .hold_o(hold)
  );

  assign ctl = ctl_t'({hold[DIV_W-1:0], hold[POS_DE], hold[POS_REF+:REF_W],
                       hold[POS_CP], hold[POS_OS], hold[POS_TST]});

  sctl_port_mux #(.NUM_PORTS(NUM_PORTS)) u_mux (
    .bits_i(hold[POS_PORT+:NUM_PORTS]), .tst_i(ctl.tst),
    .fpd_half_i, .fcomp_i, .port_o
  );

  assign div_ratio_o = ctl.div;
  assign presc_en_o  = ctl.presc;
  assign ref_code_o  = ctl.refc;
  assign cp_cur_o    = ctl.cp;
  assign drive_off_o = ctl.drv_off;
  assign test_en_o   = ctl.tst;
  assign illegal_o   = ctl.tst & cp_disable_i;

  AST_CTL_STABLE_NO_TC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !div_tc_i |=> $stable(div_ratio_o) && $stable(test_en_o)); // R4
  AST_PORTS_PLAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_en_o |-> port_o == hold[POS_PORT+:NUM_PORTS]); // R6
endmodule

// File: tb/synth_ctl_port_bench.sv
`timescale 1ns/1ps
module synth_ctl_port_bench;
  localparam int W = 28;
  logic clk = 0, rst_n = 0;
  logic sclk = 0, sdata = 0, sen = 0, tc = 0, fpd = 0, fcp = 0, cpd = 0;
  logic [16:0] div_o; logic presc_o, cp_o, drv_o, tst_o, lerr_o, ill_o;
  logic [2:0] ref_o; logic [3:0] port_o;
  int n_chk = 0, n_bad = 0, cyc = 0;

  always #10 clk = ~clk;

  synth_ctl_port u_synth_ctl_port (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdata_i(sdata), .sen_i(sen),
    .div_tc_i(tc), .fpd_half_i(fpd), .fcomp_i(fcp), .cp_disable_i(cpd),
    .div_ratio_o(div_o), .presc_en_o(presc_o), .ref_code_o(ref_o), .cp_cur_o(cp_o),
    .drive_off_o(drv_o), .test_en_o(tst_o), .port_o(port_o),
    .len_err_o(lerr_o), .illegal_o(ill_o));

  // behavioural reference
  bit q[$];
  logic [W-1:0] m_staged, m_hold;
  bit m_pend, m_lerr, m_sclk_q, m_sen_q;
  int m_cnt;

  function automatic logic [W-1:0] q_word();
    logic [W-1:0] v = '0;
    foreach (q[i]) v = {v[W-2:0], q[i]};
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); for (int i = 0; i < W; i++) q.push_back(1'b0);
      m_staged = '0; m_hold = '0; m_pend = 0; m_lerr = 0;
      m_sclk_q = 0; m_sen_q = 0; m_cnt = 0;
    end else begin
      if (m_pend && tc) begin m_hold = m_staged; m_pend = 0; end
      if (m_sen_q && !sen) begin
        m_staged = q_word(); m_pend = 1; m_lerr = (m_cnt != W); m_cnt = 0;
      end else if (sen && !m_sen_q) m_cnt = 0;
      else if (sclk && !m_sclk_q && sen && m_sen_q) begin
        q.push_back(sdata); void'(q.pop_front()); m_cnt++;
      end
      m_sclk_q = sclk; m_sen_q = sen;
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      chk("R2", "div", 32'(div_o), 32'(m_hold[16:0]));
      chk("R2", "ctl", {presc_o, ref_o, cp_o, drv_o, tst_o},
          {m_hold[17], m_hold[20:18], m_hold[21], m_hold[22], m_hold[23]});
      if (m_hold[23])
        chk("R7", "ports", 32'(port_o), {m_hold[27:26], fcp, fpd});
      else
        chk("R6", "ports", 32'(port_o), 32'(m_hold[27:24]));
      chk("R8", "illegal", 32'(ill_o), 32'(m_hold[23] & cpd));
      chk("R9", "len_err", 32'(lerr_o), 32'(m_lerr));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [31:0] mk(logic [3:0] p, logic t, logic os, logic c,
                                     logic [2:0] r, logic de, logic [16:0] d);
    return 32'({p, t, os, c, r, de, d});
  endfunction

  task automatic send(logic [31:0] v, int n);
    @(negedge clk) sen = 1;
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) begin sdata = v[n-1-i]; sclk = 0; end
      @(negedge clk) sclk = 1;
      @(negedge clk) sclk = 0;
    end
    @(negedge clk) sen = 0;
    @(negedge clk);
  endtask

  task automatic pulse_tc();
    @(negedge clk) tc = 1;
    @(negedge clk) tc = 0;
  endtask

  task automatic settle();
    @(posedge clk); #6;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    settle();
    chk("R1", "div after reset", 32'(div_o), 0);
    chk("R1", "ports after reset", 32'(port_o), 0);
    chk("R1", "flags after reset", {lerr_o, ill_o, tst_o, presc_o}, 0);

    send(mk(4'b1010, 0, 1, 1, 3'b101, 1, 17'h12345), 28);
    settle();
    chk("R4", "div before tc", 32'(div_o), 0);
    repeat (10) @(negedge clk);
    settle();
    chk("R5", "still pending", 32'(div_o), 0);
    pulse_tc(); settle();
    chk("R4", "div after tc", 32'(div_o), 32'h12345);
    chk("R2", "fields", {presc_o, ref_o, cp_o, drv_o, tst_o}, 7'b1_101_1_1_0);
    chk("R6", "ports", 32'(port_o), 32'b1010);
    chk("R9", "good length", 32'(lerr_o), 0);

    // clock edges with enable low
    for (int i = 0; i < 6; i++) begin
      @(negedge clk) begin sdata = 1; sclk = 1; end
      @(negedge clk) sclk = 0;
    end
    send(0, 0); pulse_tc(); settle();
    chk("R3", "div unchanged", 32'(div_o), 32'h12345);
    chk("R3", "ports unchanged", 32'(port_o), 32'b1010);
    chk("R9", "empty frame flag", 32'(lerr_o), 1);

    send(mk(4'b0001, 0, 0, 0, 3'b010, 0, 17'h00F0F), 28);
    send(mk(4'b0110, 0, 0, 1, 3'b011, 1, 17'h1C3A5), 28);
    pulse_tc(); settle();
    chk("R5", "newer word wins", 32'(div_o), 32'h1C3A5);
    chk("R6", "ports newer", 32'(port_o), 32'b0110);

    send(mk(4'b1100, 1, 0, 0, 3'b000, 0, 17'h00001), 28);
    pulse_tc();
    @(negedge clk) begin fpd = 1; fcp = 0; end
    settle();
    chk("R7", "port0 fpd", 32'(port_o), 32'b1101);
    @(negedge clk) begin fpd = 0; fcp = 1; end
    settle();
    chk("R7", "port1 fcomp", 32'(port_o), 32'b1110);
    chk("R8", "legal", 32'(ill_o), 0);
    @(negedge clk) cpd = 1;
    settle();
    chk("R8", "forbidden", 32'(ill_o), 1);

    send(32'hABCDE, 20); settle();
    chk("R9", "short flag", 32'(lerr_o), 1);
    pulse_tc(); settle();
    chk("R9", "short retained", 32'(div_o), 32'h0BCDE);
    chk("R8", "test off", 32'(ill_o), 0);

    send(32'h2F0F_1234, 30); settle();
    chk("R9", "long flag", 32'(lerr_o), 1);
    pulse_tc(); settle();
    chk("R9", "long keeps tail", 32'(div_o), 32'h11234);

    send(mk(4'b0011, 0, 0, 0, 3'b111, 1, 17'h0AAAA), 28); settle();
    chk("R9", "flag cleared", 32'(lerr_o), 0);
    pulse_tc(); settle();
    chk("R2", "ref code", 32'(ref_o), 7);

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule